// File: doc/BRIEF.md
# Four-Channel DMA Register Port

This block is the processor-facing register file of a four-channel, byte-wide DMA engine. The processor reaches it through an 8-bit I/O bus that has a 5-bit port address, a write strobe, a read strobe and a data byte. Through this bus it programs, for each channel, a 16-bit transfer address, a 16-bit transfer count, a mode field, a mask bit and an 8-bit page latch. The programmed state is driven out to a transfer sequencer, together with an armed flag and a filtered request line for each channel.

The address and count are 16 bits wide but only 8 data lines are available. Both values are therefore loaded as two bytes through one port. A single byte-order flip-flop, shared by all channels, selects which byte the next access reaches. A dedicated port write forces that flip-flop back to the low byte.

The sequencer reports each completed byte transfer with a step strobe and a channel number. A step moves the channel's current address and current count on. When a step is made at a count of zero, a terminal-count flag is latched, and the processor collects these flags through a status port.

Top module: `dma_regport`

## Requirements
- R1: Ports 0 to 7 hold the channel registers. Port 2n is the address of channel n and port 2n+1 is its count. Each 16-bit value is loaded as two byte writes, low byte first then high byte. Each write loads the same byte of both the base copy and the current copy.
- R2: One byte-order flip-flop is shared by all channels. It toggles after every read or write of ports 0 to 7. A read of ports 0 to 7 returns the selected byte of the current copy.
- R3: A write of any value to port 11 makes the next access to ports 0 to 7 target the low byte.
- R4: After reset, all four mask bits are set (no channel is armed), the byte-order flip-flop selects the low byte, and all addresses, counts, pages, modes and terminal-count flags are zero.
- R5: A write to port 10 programs one channel's mode. Bits 1:0 select the channel. Bit 2 sets the direction (1 = memory-to-I/O, 0 = I/O-to-memory). Bits 4:3 set the transfer type (00 demand, 01 single, 10 block, 11 cascade).
- R6: A write to port 9 changes one mask bit. Bits 1:0 select the channel and bit 2 is the new mask value. A channel is armed exactly when its mask bit is clear.
- R7: A masked channel ignores its request input. The request output to the sequencer and the pending bits reported in the status byte are both the request input ANDed with the armed flag.
- R8: Ports 16 to 19 are the page latches of channels 0 to 3. Each latch can be written and read back. Stepping never changes a page latch, and accesses to the page ports leave the byte-order flip-flop unchanged.
- R9: A step increments the channel's current address, wrapping modulo 2^16, and decrements its current count. The base copies are left unchanged. If a count write to the same channel falls in the same cycle, the write takes precedence.
- R10: A step made while the current count is zero sets that channel's terminal-count flag and wraps the count to 0xFFFF. A programmed count of N-1 therefore raises the flag on the Nth step.
- R11: A read of port 8 returns the terminal-count flags in bits 3:0 and the pending requests in bits 7:4. The read clears the terminal-count flags, except for a flag that is set in the same cycle. Reads of ports that are write-only or unmapped return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 5 | Port address |
| io_wr | input | 1 | Write strobe, sampled on the clock edge |
| io_rd | input | 1 | Read strobe; its side effects take place on the clock edge |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational from io_addr |
| drq | input | 4 | Per-channel transfer requests |
| step_en | input | 1 | One byte transferred on step_ch |
| step_ch | input | 2 | Channel that made the transfer |
| armed | output | 4 | Per-channel armed flag (mask bit clear) |
| req_out | output | 4 | Requests from armed channels only |
| mode_dir | output | 4 | Per-channel direction bit |
| mode_type | output | 8 | Per-channel 2-bit transfer type |
| page_flat | output | 32 | Page latches, channel n at bits 8n+7:8n |
| base_addr_flat | output | 64 | Base addresses, channel n at bits 16n+15:16n |
| cur_addr_flat | output | 64 | Current addresses |
| base_cnt_flat | output | 64 | Base counts |
| cur_cnt_flat | output | 64 | Current counts |

## Verification
Most faults in this block come from the byte-order flip-flop. If it toggles wrongly or is shared wrongly, the very next 16-bit access shows swapped or stale bytes, either on io_rdata or on the flat address and count outputs one cycle after the write. Errors in the step arithmetic show up on the current address and count outputs one cycle after the step. Errors in terminal-count handling show up at the first status read after the count reaches zero, and again at the read that follows it. Mask faults show up at once on armed and req_out, and in the upper bits of the status byte.

// File: rtl/dma_regport_pkg.sv
package dma_regport_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [1:0] {
    XT_DEMAND  = 2'b00,
    XT_SINGLE  = 2'b01,
    XT_BLOCK   = 2'b10,
    XT_CASCADE = 2'b11
  } xfer_type_e;

  // Replace one byte of a word; hi selects the upper byte.
  function automatic logic [WORD_W-1:0] put_byte(input logic [WORD_W-1:0] w,
                                                 input logic [BYTE_W-1:0] b,
                                                 input logic hi);
    logic [WORD_W-1:0] r;
    r = w;
    if (hi) r[BYTE_W +: BYTE_W] = b;
    else    r[0 +: BYTE_W]      = b;
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] get_byte(input logic [WORD_W-1:0] w,
                                                 input logic hi);
    return hi ? w[BYTE_W +: BYTE_W] : w[0 +: BYTE_W];
  endfunction

  function automatic logic [WORD_W-1:0] addr_next(input logic [WORD_W-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic [WORD_W-1:0] cnt_next(input logic [WORD_W-1:0] c);
    return c - 1'b1;
  endfunction
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_we,
  input  logic              cnt_we,
  input  logic              hi_sel,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              page_we,
  input  logic              mode_we,
  input  logic [2:0]        mode_bits,
  input  logic              step,
  output logic [WORD_W-1:0] base_addr,
  output logic [WORD_W-1:0] cur_addr,
  output logic [WORD_W-1:0] base_cnt,
  output logic [WORD_W-1:0] cur_cnt,
  output logic [BYTE_W-1:0] page,
  output logic              mode_dir,
  output logic [1:0]        mode_type,
  output logic              tc_hit
);
  assign tc_hit = step && !cnt_we && (cur_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr <= '0;
      cur_addr  <= '0;
      base_cnt  <= '0;
      cur_cnt   <= '0;
      page      <= '0;
      mode_dir  <= 1'b0;
      mode_type <= XT_DEMAND;
    end else begin
      if (addr_we) begin
        base_addr <= put_byte(base_addr, wbyte, hi_sel);
        cur_addr  <= put_byte(cur_addr, wbyte, hi_sel);
      end else if (step) begin
        cur_addr  <= addr_next(cur_addr);
      end
      if (cnt_we) begin
        base_cnt <= put_byte(base_cnt, wbyte, hi_sel);
        cur_cnt  <= put_byte(cur_cnt, wbyte, hi_sel);
      end else if (step) begin
        cur_cnt  <= cnt_next(cur_cnt);
      end
      if (page_we) page <= wbyte;
      if (mode_we) begin
        mode_dir  <= mode_bits[0];
        mode_type <= mode_bits[2:1];
      end
    end
  end

  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !page_we) |=> $stable(page)); // R8
  AST_CNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cnt_we) |=> (cur_cnt == $past(cur_cnt) - 16'd1)); // R9
  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !addr_we) |=> $stable(base_addr)); // R9
endmodule

// File: rtl/dma_stat_regs.sv
module dma_stat_regs #(
  parameter int NCH = 4,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mask_we,
  input  logic [CH_W-1:0] mask_ch,
  input  logic            mask_val,
  input  logic            stat_rd,
  input  logic [NCH-1:0]  tc_set,
  output logic [NCH-1:0]  mask,
  output logic [NCH-1:0]  tc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '1;
      tc   <= '0;
    end else begin
      if (mask_we) mask[mask_ch] <= mask_val;
      tc <= (stat_rd ? '0 : tc) | tc_set;
    end
  end

  AST_TC_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && tc_set == '0) |=> (tc == '0)); // R11
  AST_TC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_set != '0) |=> ((tc & $past(tc_set)) == $past(tc_set))); // R10
  AST_MASK_WR: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask[$past(mask_ch)] == $past(mask_val))); // R6
endmodule

// File: rtl/dma_regport.sv
module dma_regport
  import dma_regport_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 5,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       io_addr,
  input  logic                io_wr,
  input  logic                io_rd,
  input  logic [BYTE_W-1:0]   io_wdata,
  output logic [BYTE_W-1:0]   io_rdata,
  input  logic [NCH-1:0]      drq,
  input  logic                step_en,
  input  logic [CH_W-1:0]     step_ch,
  output logic [NCH-1:0]      armed,
  output logic [NCH-1:0]      req_out,
  output logic [NCH-1:0]      mode_dir,
  output logic [2*NCH-1:0]    mode_type,
  output logic [BYTE_W*NCH-1:0] page_flat,
  output logic [WORD_W*NCH-1:0] base_addr_flat,
  output logic [WORD_W*NCH-1:0] cur_addr_flat,
  output logic [WORD_W*NCH-1:0] base_cnt_flat,
  output logic [WORD_W*NCH-1:0] cur_cnt_flat
);
  localparam logic [AW-1:0] P_STAT  = AW'(2*NCH);
  localparam logic [AW-1:0] P_MASK  = AW'(2*NCH + 1);
  localparam logic [AW-1:0] P_MODE  = AW'(2*NCH + 2);
  localparam logic [AW-1:0] P_CLRP  = AW'(2*NCH + 3);
  localparam logic [AW-1:0] P_PAGE0 = AW'(16);

  logic              byte_ptr;
  logic              is_word, is_page, word_acc, ptr_clr, stat_rd;
  logic [CH_W-1:0]   word_ch, page_ch;
  logic [NCH-1:0]    mask, tc, tc_hit;
  logic [WORD_W-1:0] cur_addr [NCH];
  logic [WORD_W-1:0] cur_cnt  [NCH];
  logic [BYTE_W-1:0] page     [NCH];

  assign is_word  = io_addr < AW'(2*NCH);
  assign is_page  = (io_addr >= P_PAGE0) && (io_addr < P_PAGE0 + AW'(NCH));
  assign word_ch  = io_addr[CH_W:1];
  assign page_ch  = io_addr[CH_W-1:0];
  assign word_acc = (io_wr || io_rd) && is_word;
  assign ptr_clr  = io_wr && (io_addr == P_CLRP);
  assign stat_rd  = io_rd && (io_addr == P_STAT);
  assign armed    = ~mask;
  assign req_out  = drq & armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        byte_ptr <= 1'b0;
    else if (ptr_clr)  byte_ptr <= 1'b0;
    else if (word_acc) byte_ptr <= ~byte_ptr;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic sel_w, sel_p;
    assign sel_w = io_wr && is_word && (word_ch == CH_W'(g));
    assign sel_p = io_wr && is_page && (page_ch == CH_W'(g));
    dma_chan_regs u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_we   (sel_w && !io_addr[0]),
      .cnt_we    (sel_w && io_addr[0]),
      .hi_sel    (byte_ptr),
      .wbyte     (io_wdata),
      .page_we   (sel_p),
      .mode_we   (io_wr && io_addr == P_MODE && io_wdata[1:0] == 2'(g)),
      .mode_bits (io_wdata[4:2]),
      .step      (step_en && step_ch == CH_W'(g)),
      .base_addr (base_addr_flat[g*WORD_W +: WORD_W]),
      .cur_addr  (cur_addr[g]),
      .base_cnt  (base_cnt_flat[g*WORD_W +: WORD_W]),
      .cur_cnt   (cur_cnt[g]),
      .page      (page[g]),
      .mode_dir  (mode_dir[g]),
      .mode_type (mode_type[2*g +: 2]),
      .tc_hit    (tc_hit[g])
    );
    assign cur_addr_flat[g*WORD_W +: WORD_W] = cur_addr[g];
    assign cur_cnt_flat[g*WORD_W +: WORD_W]  = cur_cnt[g];
    assign page_flat[g*BYTE_W +: BYTE_W]     = page[g];
  end

  dma_stat_regs #(.NCH(NCH)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .mask_we  (io_wr && io_addr == P_MASK),
    .mask_ch  (io_wdata[CH_W-1:0]),
    .mask_val (io_wdata[2]),
    .stat_rd  (stat_rd),
    .tc_set   (tc_hit),
    .mask     (mask),
    .tc       (tc)
  );

  always_comb begin
    io_rdata = '0;
    if (io_rd) begin
      if (is_word)
        io_rdata = get_byte(io_addr[0] ? cur_cnt[word_ch] : cur_addr[word_ch], byte_ptr);
      else if (is_page)
        io_rdata = page[page_ch];
      else if (io_addr == P_STAT)
        io_rdata = {req_out, tc};
    end
  end

  AST_PTR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (word_acc && !ptr_clr) |=> (byte_ptr != $past(byte_ptr))); // R2
  AST_PTR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> !byte_ptr); // R3
  AST_PAGE_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    ((io_wr || io_rd) && is_page) |=> $stable(byte_ptr)); // R8
endmodule

// File: tb/tb_dma_regport.sv
module tb_dma_regport;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [3:0]  drq = '0;
  logic        step_en = 1'b0;
  logic [1:0]  step_ch = '0;
  logic [3:0]  armed, req_out, mode_dir;
  logic [7:0]  mode_type;
  logic [31:0] page_flat;
  logic [63:0] base_addr_flat, cur_addr_flat, base_cnt_flat, cur_cnt_flat;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  dma_regport dut (.*);

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1'b1; #1 d = io_rdata;
    @(negedge clk); io_rd = 1'b0;
  endtask

  task automatic step(input logic [1:0] ch);
    @(negedge clk); step_en = 1'b1; step_ch = ch;
    @(negedge clk); step_en = 1'b0;
  endtask

  // {op(0=write,1=read-check), addr, data, expected}
  localparam logic [31:0] VEC [16] = '{
    {4'd0, 7'd0, 5'd0,  8'h34, 8'h00},  // R1 ch0 addr low
    {4'd0, 7'd0, 5'd0,  8'h12, 8'h00},  // R1 ch0 addr high
    {4'd0, 7'd0, 5'd1,  8'h02, 8'h00},  // R1 ch0 count low
    {4'd0, 7'd0, 5'd1,  8'h00, 8'h00},  // R1 ch0 count high
    {4'd1, 7'd0, 5'd0,  8'h00, 8'h34},  // R2 read low
    {4'd1, 7'd0, 5'd0,  8'h00, 8'h12},  // R2 read high
    {4'd0, 7'd0, 5'd6,  8'hCD, 8'h00},  // R1 ch3 addr low
    {4'd0, 7'd0, 5'd11, 8'h00, 8'h00},  // R3 clear pointer
    {4'd0, 7'd0, 5'd6,  8'hEF, 8'h00},  // R3 low again
    {4'd0, 7'd0, 5'd6,  8'hAB, 8'h00},  // R1 high
    {4'd1, 7'd0, 5'd6,  8'h00, 8'hEF},  // R2
    {4'd1, 7'd0, 5'd6,  8'h00, 8'hAB},  // R2
    {4'd0, 7'd0, 5'd17, 8'h5A, 8'h00},  // R8 page1
    {4'd1, 7'd0, 5'd17, 8'h00, 8'h5A},  // R8
    {4'd1, 7'd0, 5'd8,  8'h00, 8'h00},  // R11 empty status
    {4'd1, 7'd0, 5'd10, 8'h00, 8'h00}   // R11 write-only port reads zero
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4 armed", armed, 4'h0);
    check("R4 cur_addr", cur_addr_flat, 64'h0);
    check("R4 page/mode", {page_flat, mode_type, mode_dir}, 44'h0);
    rd(5'd8, d); check("R4 status", d, 8'h00);

    foreach (VEC[i]) begin
      if (VEC[i][31:28] == 4'd0) wr(VEC[i][20:16], VEC[i][15:8]);
      else begin
        rd(VEC[i][20:16], d);
        check($sformatf("table(R1,R2,R3,R8,R11) row %0d", i), d, VEC[i][7:0]);
      end
    end
    check("R1 base+cur ch0 addr", {base_addr_flat[15:0], cur_addr_flat[15:0]}, 32'h1234_1234);
    check("R1 ch3 addr", cur_addr_flat[63:48], 16'hABEF);

    // R6 single mask port
    wr(5'd9, 8'h00); check("R6 clear ch0", armed, 4'b0001);
    wr(5'd9, 8'h04); check("R6 set ch0", armed, 4'b0000);
    wr(5'd9, 8'h02); wr(5'd9, 8'h00); check("R6 clear ch2,ch0", armed, 4'b0101);

    // R7 masked request suppression
    drq = 4'b1111; @(negedge clk);
    check("R7 req_out", req_out, 4'b0101);
    rd(5'd8, d); check("R7 status pending", d, 8'h50);
    drq = 4'b0000;

    // R5 mode: ch1, dir=1, block
    wr(5'd10, 8'h15);
    check("R5 mode ch1", {mode_type[3:2], mode_dir[1]}, 3'b101);
    wr(5'd10, 8'h18); // ch0 cascade, dir 0
    check("R5 mode ch0", {mode_type[1:0], mode_dir[0]}, 3'b110);

    // R9 R10 stepping ch0, count 2 -> tc on third step
    step(2'd0);
    check("R9 step addr/cnt", {cur_addr_flat[15:0], cur_cnt_flat[15:0]}, 32'h1235_0001);
    step(2'd0); step(2'd0);
    check("R10 wrap count", cur_cnt_flat[15:0], 16'hFFFF);
    check("R9 base kept", {base_addr_flat[15:0], base_cnt_flat[15:0]}, 32'h1234_0002);
    step(2'd1);
    check("R8 page kept", page_flat[15:8], 8'h5A);
    rd(5'd8, d); check("R10 tc flags", d, 8'h03);
    rd(5'd8, d); check("R11 cleared on read", d, 8'h00);

    // R9 address wrap, page unchanged
    wr(5'd18, 8'h07);
    wr(5'd11, 8'h00); wr(5'd4, 8'hFF); wr(5'd4, 8'hFF);
    step(2'd2);
    check("R9 addr wrap", cur_addr_flat[47:32], 16'h0000);
    check("R8 page2 kept", page_flat[23:16], 8'h07);

    // R2 a read toggles pointer
    wr(5'd11, 8'h00);
    rd(5'd0, d); check("R2 read low current", d, 8'h37);
    wr(5'd0, 8'h99);
    check("R2 write lands high", {base_addr_flat[15:0], cur_addr_flat[15:0]}, 32'h9934_9937);

    // R9 count write beats step same cycle
    wr(5'd11, 8'h00);
    @(negedge clk); io_addr = 5'd3; io_wdata = 8'h44; io_wr = 1'b1; step_en = 1'b1; step_ch = 2'd1;
    @(negedge clk); io_wr = 1'b0; step_en = 1'b0;
    check("R9 write wins", cur_cnt_flat[31:16], 16'hFF44);

    // R4 reset again
    @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    check("R4 re-reset", {armed, cur_cnt_flat[15:0]}, 20'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule